// File: doc/BRIEF.md
# Indexed Chipset Configuration Register Bank

This block is the configuration register bank of a legacy PC chipset. The host reaches it through two adjacent I/O ports. A write to the even port selects one of 256 byte-wide registers. Reads and writes to the odd port then move data into or out of the selected register. Every register comes out of reset with a fixed value. Reads of the even port return the current selection.

Several control outputs are decoded straight from specific register bits and registered before they leave the block:
- an alternate gate A20 line,
- a wait-state count,
- an external cache enable,
- a top-of-memory relocation size in kilobytes.

Register 00h always reads back with bit 6 set, which reports that an external cache is fitted. The host uses the block by writing the index, then the data. The decoded outputs feed the memory and bus controllers elsewhere in the chip.

Top module: `chipset_cfg_bank`

## Requirements
- R1: After reset the index is 00h. Register 00h holds 40h, register 02h holds 0Ch, register 40h holds 08h and every other register holds 00h. The decoded outputs are a20_alt=0, wait_states=0, ext_cache_en=0 and reloc_kb=0.
- R2: A strobed write (io_sel=1, io_wr=1) to address A8h loads io_wdata into the index on that clock edge. A strobed read (io_sel=1, io_wr=0) of A8h returns the index on io_rdata in the same cycle.
- R3: A strobed write to A9h stores io_wdata into the register selected by the index on that clock edge. A strobed read of A9h returns that register combinationally.
- R4: A read of register 00h through A9h always has bit 6 set, whatever was written. The other bits show the stored value.
- R5: A strobe at any address other than A8h or A9h changes neither the index nor any register, and its read returns 00h.
- R6: a20_alt equals bit 0 of register 01h. It changes on the second rising edge after the write strobe is sampled.
- R7: wait_states is decoded from register 33h using the pair {bit 3, bit 0}: 00 gives 0, 10 gives 1, 11 gives 2, and 01 gives 0. The output is due on the second edge after the write.
- R8: ext_cache_en is the inverse of bit 3 of register 40h, so the cache is enabled when that bit is clear. The output is due on the second edge after the write.
- R9: reloc_kb is taken from register 2Dh. Bit 7 alone gives 256. Bits 7 and 6 together give 384. Any value with bit 7 clear gives 0. The output is due on the second edge after the write.
- R10: Without a read strobe to A8h or A9h, io_rdata is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | I/O cycle strobe, one cycle per access |
| io_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid during a read strobe |
| a20_alt | output | 1 | Alternate gate A20 control |
| wait_states | output | 2 | Memory wait-state count (0 to 2) |
| ext_cache_en | output | 1 | External cache enable |
| reloc_kb | output | 9 | Top-of-memory relocation size in KB (0, 256, 384) |

## Verification
Read data is combinational, so each read check samples io_rdata one nanosecond after the strobe is driven, before any edge passes. A register or index write lands on the first rising edge that samples the strobe. Each decoded output passes through one more register, so it is due on the second edge. The bench therefore waits one extra falling edge after each write task before it compares an output. For gate A20 it also confirms the output has not yet moved right after the first edge. The decoder sweeps drive all 256 values of each control register and compare against expectations restated arithmetically in the bench.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  localparam int IDX_W    = 8;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int WAIT_W   = 2;
  localparam int RELOC_W  = 9;

  // register positions the decoders depend on
  localparam logic [IDX_W-1:0] REG_STATUS = 8'h00;
  localparam logic [IDX_W-1:0] REG_GATE   = 8'h01;
  localparam logic [IDX_W-1:0] REG_BUSCLK = 8'h02;
  localparam logic [IDX_W-1:0] REG_RELOC  = 8'h2D;
  localparam logic [IDX_W-1:0] REG_WAIT   = 8'h33;
  localparam logic [IDX_W-1:0] REG_CACHE  = 8'h40;

  // bit forced high on status readback: cache fitted
  localparam logic [DATA_W-1:0] STATUS_FORCE = 8'h40;

  typedef struct packed {
    logic idx_wr;
    logic dat_wr;
    logic idx_rd;
    logic dat_rd;
  } port_op_t;

  function automatic logic [DATA_W-1:0] reg_reset_value(input logic [IDX_W-1:0] idx);
    case (idx)
      REG_STATUS: return 8'h40;
      REG_BUSCLK: return 8'h0C;
      REG_CACHE:  return 8'h08;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic gate_decode(input logic [DATA_W-1:0] v);
    return v[0];
  endfunction

  function automatic logic [WAIT_W-1:0] wait_decode(input logic [DATA_W-1:0] v);
    case ({v[3], v[0]})
      2'b10:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic cache_decode(input logic [DATA_W-1:0] v);
    return ~v[3];
  endfunction

  function automatic logic [RELOC_W-1:0] reloc_decode(input logic [DATA_W-1:0] v);
    if (!v[7])     return 9'd0;
    else if (v[6]) return 9'd384;
    else           return 9'd256;
  endfunction

  function automatic logic [DATA_W-1:0] status_view(input logic [IDX_W-1:0] idx,
                                                    input logic [DATA_W-1:0] v);
    return (idx == REG_STATUS) ? (v | STATUS_FORCE) : v;
  endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_bank_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00A8
) (
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  output port_op_t          op
);

  logic hit;
  logic is_data;

  assign hit     = io_sel && (io_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign is_data = io_addr[0];

  always_comb begin
    op        = '0;
    op.idx_wr = hit &&  io_wr && !is_data;
    op.dat_wr = hit &&  io_wr &&  is_data;
    op.idx_rd = hit && !io_wr && !is_data;
    op.dat_rd = hit && !io_wr &&  is_data;
  end

endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
  import cfg_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  port_op_t          op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [IDX_W-1:0]  index,
  output logic [DATA_W-1:0] tap_gate,
  output logic [DATA_W-1:0] tap_wait,
  output logic [DATA_W-1:0] tap_cache,
  output logic [DATA_W-1:0] tap_reloc
);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [IDX_W-1:0]  index_q;

  always_ff @(posedge clk) begin
    if (!rst_n) index_q <= '0;
    else if (op.idx_wr) index_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_reset_value(IDX_W'(i));
    end else if (op.dat_wr) begin
      regs[index_q] <= wdata;
    end
  end

  always_comb begin
    if (op.idx_rd)      rdata = index_q;
    else if (op.dat_rd) rdata = status_view(index_q, regs[index_q]);
    else                rdata = '0;
  end

  assign index     = index_q;
  assign tap_gate  = regs[REG_GATE];
  assign tap_wait  = regs[REG_WAIT];
  assign tap_cache = regs[REG_CACHE];
  assign tap_reloc = regs[REG_RELOC];

endmodule

// File: rtl/cfg_ctrl_decode.sv
module cfg_ctrl_decode
  import cfg_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  gate_v,
  input  logic [DATA_W-1:0]  wait_v,
  input  logic [DATA_W-1:0]  cache_v,
  input  logic [DATA_W-1:0]  reloc_v,
  output logic               a20_alt,
  output logic [WAIT_W-1:0]  wait_states,
  output logic               ext_cache_en,
  output logic [RELOC_W-1:0] reloc_kb
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a20_alt      <= gate_decode(reg_reset_value(REG_GATE));
      wait_states  <= wait_decode(reg_reset_value(REG_WAIT));
      ext_cache_en <= cache_decode(reg_reset_value(REG_CACHE));
      reloc_kb     <= reloc_decode(reg_reset_value(REG_RELOC));
    end else begin
      a20_alt      <= gate_decode(gate_v);
      wait_states  <= wait_decode(wait_v);
      ext_cache_en <= cache_decode(cache_v);
      reloc_kb     <= reloc_decode(reloc_v);
    end
  end

endmodule

// File: rtl/chipset_cfg_bank.sv
module chipset_cfg_bank
  import cfg_bank_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00A8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              a20_alt,
  output logic [1:0]        wait_states,
  output logic              ext_cache_en,
  output logic [8:0]        reloc_kb
);

  port_op_t          op;
  logic              idx_wr_evt;
  logic              dat_wr_evt;
  logic              idx_rd_evt;
  logic              dat_rd_evt;
  logic [IDX_W-1:0]  cur_index;
  logic [DATA_W-1:0] t_gate, t_wait, t_cache, t_reloc;

  cfg_port_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_port (
    .io_sel (io_sel),
    .io_wr  (io_wr),
    .io_addr(io_addr),
    .op     (op)
  );

  assign idx_wr_evt = op.idx_wr;
  assign dat_wr_evt = op.dat_wr;
  assign idx_rd_evt = op.idx_rd;
  assign dat_rd_evt = op.dat_rd;

  cfg_reg_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .wdata    (io_wdata),
    .rdata    (io_rdata),
    .index    (cur_index),
    .tap_gate (t_gate),
    .tap_wait (t_wait),
    .tap_cache(t_cache),
    .tap_reloc(t_reloc)
  );

  cfg_ctrl_decode u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_v      (t_gate),
    .wait_v      (t_wait),
    .cache_v     (t_cache),
    .reloc_v     (t_reloc),
    .a20_alt     (a20_alt),
    .wait_states (wait_states),
    .ext_cache_en(ext_cache_en),
    .reloc_kb    (reloc_kb)
  );

endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk
  import cfg_bank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              a20_alt,
  input logic [1:0]        wait_states,
  input logic              ext_cache_en,
  input logic [8:0]        reloc_kb,
  input logic              idx_wr_evt,
  input logic              dat_wr_evt,
  input logic              idx_rd_evt,
  input logic              dat_rd_evt,
  input logic [IDX_W-1:0]  cur_index
);

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr_evt |=> cur_index == $past(io_wdata));

  // R4
  status_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd_evt && cur_index == REG_STATUS) |-> io_rdata[6]);

  // R6
  a20_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dat_wr_evt && cur_index == REG_GATE, 2) |-> a20_alt == $past(io_wdata[0], 2));

  // R7
  wait_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_states != 2'd3);

  // R8
  cache_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dat_wr_evt && cur_index == REG_CACHE, 2) |-> ext_cache_en == !$past(io_wdata[3], 2));

  // R9
  reloc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reloc_kb == 9'd0 || reloc_kb == 9'd256 || reloc_kb == 9'd384);

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_rd_evt || dat_rd_evt) |-> io_rdata == 8'h00);

endmodule

bind chipset_cfg_bank cfg_bank_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .a20_alt     (a20_alt),
  .wait_states (wait_states),
  .ext_cache_en(ext_cache_en),
  .reloc_kb    (reloc_kb),
  .idx_wr_evt  (idx_wr_evt),
  .dat_wr_evt  (dat_wr_evt),
  .idx_rd_evt  (idx_rd_evt),
  .dat_rd_evt  (dat_rd_evt),
  .cur_index   (cur_index)
);

// File: tb/tb_chipset_cfg_bank.sv
module tb_chipset_cfg_bank;

  localparam logic [15:0] A_IDX = 16'h00A8;
  localparam logic [15:0] A_DAT = 16'h00A9;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_sel = 0;
  logic        io_wr = 0;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata;
  logic        a20_alt;
  logic [1:0]  wait_states;
  logic        ext_cache_en;
  logic [8:0]  reloc_kb;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chipset_cfg_bank dut (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .a20_alt(a20_alt),
    .wait_states(wait_states), .ext_cache_en(ext_cache_en), .reloc_kb(reloc_kb)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_sel = 1; io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_sel = 0; io_wr = 0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_sel = 1; io_wr = 0; io_addr = a;
    #1 d = io_rdata;
    @(negedge clk);
    io_sel = 0;
  endtask

  function automatic logic [7:0] exp_reset(input int i);
    if (i == 0)     return 8'h40;
    if (i == 2)     return 8'h0C;
    if (i == 8'h40) return 8'h08;
    return 8'h00;
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  function automatic logic [1:0] exp_wait(input logic [7:0] v);
    int n;
    n = v[3] ? 1 + int'(v[0]) : 0;
    return 2'(n);
  endfunction

  function automatic logic [8:0] exp_reloc(input logic [7:0] v);
    return v[7] ? (9'd256 + (v[6] ? 9'd128 : 9'd0)) : 9'd0;
  endfunction

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R1: reset state of outputs and index
    @(negedge clk);
    check("R1", "a20_alt", 16'(a20_alt), 16'd0);
    check("R1", "wait_states", 16'(wait_states), 16'd0);
    check("R1", "ext_cache_en", 16'(ext_cache_en), 16'd0);
    check("R1", "reloc_kb", 16'(reloc_kb), 16'd0);
    io_read(A_IDX, r);
    check("R1", "index", 16'(r), 16'h00);
    // R10: no strobe, no read data
    io_addr = A_DAT;
    #1 check("R10", "idle rdata", 16'(io_rdata), 16'h00);

    // R1: reset value of every register
    for (int i = 0; i < 256; i++) begin
      io_write(A_IDX, 8'(i));
      io_read(A_DAT, r);
      check("R1", $sformatf("reg %02h reset", i), 16'(r), 16'(exp_reset(i)));
    end

    // R3: write every register, then read every one back
    for (int i = 0; i < 256; i++) begin
      io_write(A_IDX, 8'(i));
      io_write(A_DAT, pat(i));
    end
    for (int i = 0; i < 256; i++) begin
      io_write(A_IDX, 8'(i));
      io_read(A_DAT, r);
      check("R3", $sformatf("reg %02h readback", i), 16'(r),
            16'(i == 0 ? (pat(i) | 8'h40) : pat(i)));
    end

    // R2: index readback
    io_write(A_IDX, 8'h5A);
    io_read(A_IDX, r);
    check("R2", "index readback", 16'(r), 16'h5A);

    // R4: forced status bit
    io_write(A_IDX, 8'h00);
    io_write(A_DAT, 8'h00);
    io_read(A_DAT, r);
    check("R4", "status 00 written", 16'(r), 16'h40);
    io_write(A_DAT, 8'hBF);
    io_read(A_DAT, r);
    check("R4", "status BF written", 16'(r), 16'hFF);

    // R6: a20 timing and value (pattern left bit 0 of reg 01 clear)
    io_write(A_IDX, 8'h01);
    io_write(A_DAT, 8'h01);
    check("R6", "a20 before 2nd edge", 16'(a20_alt), 16'(pat(1) & 8'h01));
    @(negedge clk);
    check("R6", "a20 after 2nd edge", 16'(a20_alt), 16'd1);
    for (int v = 0; v < 256; v++) begin
      io_write(A_DAT, 8'(v));
      @(negedge clk);
      check("R6", $sformatf("a20 v=%02h", v), 16'(a20_alt), 16'(v % 2));
    end

    // R7: wait-state sweep
    io_write(A_IDX, 8'h33);
    for (int v = 0; v < 256; v++) begin
      io_write(A_DAT, 8'(v));
      @(negedge clk);
      check("R7", $sformatf("wait v=%02h", v), 16'(wait_states), 16'(exp_wait(8'(v))));
    end

    // R8: cache enable sweep
    io_write(A_IDX, 8'h40);
    for (int v = 0; v < 256; v++) begin
      io_write(A_DAT, 8'(v));
      @(negedge clk);
      check("R8", $sformatf("cache v=%02h", v), 16'(ext_cache_en),
            16'(((v / 8) % 2) == 0));
    end

    // R9: relocation sweep
    io_write(A_IDX, 8'h2D);
    for (int v = 0; v < 256; v++) begin
      io_write(A_DAT, 8'(v));
      @(negedge clk);
      check("R9", $sformatf("reloc v=%02h", v), 16'(reloc_kb), 16'(exp_reloc(8'(v))));
    end

    // R5: foreign addresses leave state alone
    io_write(A_IDX, 8'h10);
    io_write(A_DAT, 8'h77);
    io_write(16'h00A7, 8'h22);
    io_write(16'h00AA, 8'h33);
    io_write(16'h01A8, 8'h44);
    io_write(16'h01A9, 8'h55);
    io_write(16'h00B9, 8'h66);
    io_read(A_IDX, r);
    check("R5", "index kept", 16'(r), 16'h10);
    io_read(A_DAT, r);
    check("R5", "reg 10 kept", 16'(r), 16'h77);
    io_read(16'h01A9, r);
    check("R5", "foreign read", 16'(r), 16'h00);
    io_read(16'h00AB, r);
    check("R5", "foreign read AB", 16'(r), 16'h00);

    done = 1;
    report();
  end

endmodule